// File: doc/BRIEF.md
# Bit-Test Branch and Skip Unit

This unit resolves control flow for single-bit conditional branches and flag-conditioned skips in a small 8-bit controller core. The decoder hands it one instruction at a time on an `issue` strobe. With that strobe come the instruction class, the operand form, the already-fetched value of the tested bit, the Z and CY flags, a signed 8-bit displacement and the current 20-bit program counter. The unit works out the branch condition and the sequential and target addresses. It then holds the result for the number of clocks the instruction costs, and presents the next PC on a single `done` strobe.

Two branch kinds exist. A branch-on-clear jumps when the tested bit is 0. A branch-on-set-and-clear jumps when the bit is 1, and in the same operation asks the write-back path to clear that bit at its source. The skip instructions never jump. When their flag condition holds, they arm a pending-skip register. The next instruction issued is then retired as suppressed: no branch, no clear request, and the PC steps past it. A suppressed skip does not arm a new skip.

Top module: `bit_branch_unit`

## Requirements
- R1: For class 1 (branch-on-clear) the branch is taken when `bit_val` is 0. The taken next PC is (pc + length + sign-extended disp) modulo 2^20. The not-taken next PC is (pc + length) modulo 2^20.
- R2: For class 2 (branch-on-set-and-clear) the branch is taken when `bit_val` is 1. `clr_req` is high on the `done` strobe exactly when the branch is taken, and `clr_loc` then equals the issued `form`.
- R3: The branch length is 3 bytes for forms 2 (accumulator bit) and 4 (indirect bit). It is 4 bytes for forms 0 (short direct), 1 (special register), 3 (status word), 5 (segment-prefixed indirect), 6 and 7.
- R4: `done` rises N cycles after an accepted issue, where the issue cycle counts as cycle 1. For a branch, N is 3 when not taken and 5 when taken, except form 5, which takes 4 and 6. N is 1 for skips, for class 0 and for suppressed instructions.
- R5: `busy` is high in every cycle between an accepted issue and its `done` strobe, and `issue` is ignored while `busy` is high.
- R6: A skip (class 3) has next PC = pc + 2, never takes a branch, and arms `skip_pend` when its condition holds. The condition is chosen by `skc`: 0 CY=1, 1 CY=0, 2 Z=1, 3 Z=0, 4 (Z or CY)=0, 5 (Z or CY)=1, and 6 and 7 never.
- R7: An instruction accepted while `skip_pend` is high retires after 1 cycle with `squash`=1, `taken`=0 and `clr_req`=0. Its next PC is pc plus its own length: the R3 length for branches, 2 for skips, and `plain_len` for class 0.
- R8: A suppressed instruction clears `skip_pend`, even when it is itself a skip whose condition holds.
- R9: Class 0 retires after 1 cycle with next PC = pc + `plain_len`, `taken`=0 and `clr_req`=0.
- R10: After reset, `busy`, `done` and `skip_pend` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | New instruction present this cycle |
| op | input | 2 | Class: 0 plain, 1 branch-on-clear, 2 branch-on-set-and-clear, 3 skip |
| form | input | 3 | Operand form of the tested bit |
| skc | input | 3 | Skip condition code |
| bit_val | input | 1 | Value of the tested bit |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| disp | input | 8 | Signed branch displacement |
| pc | input | 20 | PC of the issued instruction |
| plain_len | input | 3 | Byte length of a class 0 instruction |
| busy | output | 1 | Multi-cycle instruction still in progress |
| done | output | 1 | Result strobe; outputs below are valid |
| npc | output | 20 | Next PC |
| taken | output | 1 | Branch taken |
| clr_req | output | 1 | Request to clear the tested bit |
| clr_loc | output | 3 | Operand form whose bit is to be cleared |
| squash | output | 1 | Instruction retired as suppressed |
| skip_pend | output | 1 | Next instruction will be suppressed |

## Verification
Every result is due on the `done` strobe, N cycles after the issue edge, with N counted as in R4. Each scenario task drives inputs on the falling edge and samples on every following falling edge. It takes the first cycle in which `done` is high as the measured cycle count and compares that count with the N the bench derives from the inputs. On the same edge it checks `npc`, `taken`, `clr_req`, `squash` and `skip_pend`. In every earlier cycle it requires `busy` high and `done` low, so a strobe that comes early or late is reported as a wrong count rather than missed.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_BRZ   = 2'd1,
        OP_BRSC  = 2'd2,
        OP_SKIP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        FM_DIR    = 3'd0,
        FM_SFR    = 3'd1,
        FM_ACC    = 3'd2,
        FM_PSW    = 3'd3,
        FM_IND    = 3'd4,
        FM_SEGIND = 3'd5,
        FM_RSV6   = 3'd6,
        FM_RSV7   = 3'd7
    } form_e;

    typedef enum logic [2:0] {
        SK_C   = 3'd0,
        SK_NC  = 3'd1,
        SK_Z   = 3'd2,
        SK_NZ  = 3'd3,
        SK_H   = 3'd4,
        SK_NH  = 3'd5,
        SK_RV6 = 3'd6,
        SK_RV7 = 3'd7
    } skc_e;

    localparam logic [2:0] LEN_SHORT = 3'd3;
    localparam logic [2:0] LEN_LONG  = 3'd4;
    localparam logic [2:0] LEN_SKIP  = 3'd2;

    function automatic logic [2:0] branch_len(input form_e f);
        return (f == FM_ACC || f == FM_IND) ? LEN_SHORT : LEN_LONG;
    endfunction

endpackage

// File: rtl/bbu_skip_cond.sv
module bbu_skip_cond
    import bbu_pkg::*;
(
    input  logic [2:0] skc,
    input  logic       flag_z,
    input  logic       flag_cy,
    output logic       hit
);
    logic higher;

    always_comb begin
        higher = ~(flag_z | flag_cy);
        unique case (skc_e'(skc))
            SK_C:    hit = flag_cy;
            SK_NC:   hit = ~flag_cy;
            SK_Z:    hit = flag_z;
            SK_NZ:   hit = ~flag_z;
            SK_H:    hit = higher;
            SK_NH:   hit = ~higher;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bbu_target.sv
module bbu_target #(
    parameter int PC_W   = 20,
    parameter int DISP_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   jmp_pc
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        seq_pc   = pc + {{(PC_W-LEN_W){1'b0}}, len};
        jmp_pc   = seq_pc + disp_ext;
    end
endmodule

// File: rtl/bbu_cycles.sv
module bbu_cycles
    import bbu_pkg::*;
#(
    parameter int NT_CYC  = 3,
    parameter int TK_CYC  = 5,
    parameter int SEG_ADD = 1,
    parameter int CNT_W   = 3
) (
    input  logic [2:0]       form,
    input  logic             tk,
    output logic [CNT_W-1:0] cyc
);
    localparam logic [CNT_W-1:0] NT_V = CNT_W'(NT_CYC);
    localparam logic [CNT_W-1:0] TK_V = CNT_W'(TK_CYC);
    localparam logic [CNT_W-1:0] SG_V = CNT_W'(SEG_ADD);

    always_comb begin
        cyc = tk ? TK_V : NT_V;
        if (form_e'(form) == FM_SEGIND) cyc = cyc + SG_V;
    end
endmodule

// File: rtl/bit_branch_unit.sv
module bit_branch_unit
    import bbu_pkg::*;
#(
    parameter int PC_W    = 20,
    parameter int DISP_W  = 8,
    parameter int NT_CYC  = 3,
    parameter int TK_CYC  = 5,
    parameter int SEG_ADD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [1:0]        op,
    input  logic [2:0]        form,
    input  logic [2:0]        skc,
    input  logic              bit_val,
    input  logic              flag_z,
    input  logic              flag_cy,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   pc,
    input  logic [2:0]        plain_len,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   npc,
    output logic              taken,
    output logic              clr_req,
    output logic [2:0]        clr_loc,
    output logic              squash,
    output logic              skip_pend
);
    localparam int CNT_W = $clog2(TK_CYC + SEG_ADD + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  npc;
        logic             taken;
        logic             clr;
        logic [2:0]       loc;
        logic             squash;
        logic             skip;
    } st_t;

    st_t st_d, st_q;

    logic             accept;
    logic             sk_hit;
    logic             br_hit;
    logic [2:0]       len_sel;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  jmp_pc;
    logic [CNT_W-1:0] br_cyc;
    op_e              op_c;

    assign op_c   = op_e'(op);
    assign busy   = st_q.cnt > ONE;
    assign accept = issue & ~busy;

    bbu_skip_cond u_cond (
        .skc     (skc),
        .flag_z  (flag_z),
        .flag_cy (flag_cy),
        .hit     (sk_hit)
    );

    always_comb begin
        br_hit = (op_c == OP_BRSC) ? bit_val : ~bit_val;
        unique case (op_c)
            OP_BRZ, OP_BRSC: len_sel = branch_len(form_e'(form));
            OP_SKIP:         len_sel = LEN_SKIP;
            default:         len_sel = plain_len;
        endcase
    end

    bbu_target #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W),
        .LEN_W  (3)
    ) u_tgt (
        .pc     (pc),
        .len    (len_sel),
        .disp   (disp),
        .seq_pc (seq_pc),
        .jmp_pc (jmp_pc)
    );

    bbu_cycles #(
        .NT_CYC  (NT_CYC),
        .TK_CYC  (TK_CYC),
        .SEG_ADD (SEG_ADD),
        .CNT_W   (CNT_W)
    ) u_cyc (
        .form (form),
        .tk   (br_hit),
        .cyc  (br_cyc)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.npc    = seq_pc;
            st_d.cnt    = ONE;
            st_d.taken  = 1'b0;
            st_d.clr    = 1'b0;
            st_d.loc    = form;
            st_d.squash = 1'b0;
            if (st_q.skip) begin
                st_d.squash = 1'b1;
                st_d.skip   = 1'b0;
            end else begin
                unique case (op_c)
                    OP_BRZ, OP_BRSC: begin
                        st_d.cnt   = br_cyc;
                        st_d.taken = br_hit;
                        st_d.clr   = br_hit & (op_c == OP_BRSC);
                        if (br_hit) st_d.npc = jmp_pc;
                    end
                    OP_SKIP: st_d.skip = sk_hit;
                    default: ;
                endcase
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.cnt == ONE;
    assign npc       = st_q.npc;
    assign taken     = st_q.taken;
    assign clr_req   = st_q.clr;
    assign clr_loc   = st_q.loc;
    assign squash    = st_q.squash;
    assign skip_pend = st_q.skip;

endmodule

module bbu_chk (
    input logic clk,
    input logic rst_n,
    input logic issue,
    input logic busy,
    input logic done,
    input logic taken,
    input logic clr_req,
    input logic squash,
    input logic skip_pend
);
    AST_CLR_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clr_req) |-> taken); // R2
    AST_SQUASH_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && squash) |-> (!taken && !clr_req)); // R7
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R5
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4
    AST_SKIP_NOT_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_pend && issue && !busy) |=> !skip_pend); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue) |=> !done); // R4
endmodule

bind bit_branch_unit bbu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .busy      (busy),
    .done      (done),
    .taken     (taken),
    .clr_req   (clr_req),
    .squash    (squash),
    .skip_pend (skip_pend)
);

// File: tb/bit_branch_unit_tb.sv
`timescale 1ns/1ps
module bit_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  op = '0;
    logic [2:0]  form = '0;
    logic [2:0]  skc = '0;
    logic        bit_val = 1'b0;
    logic        flag_z = 1'b0;
    logic        flag_cy = 1'b0;
    logic [7:0]  disp = '0;
    logic [19:0] pc = '0;
    logic [2:0]  plain_len = 3'd1;
    logic        busy, done, taken, clr_req, squash, skip_pend;
    logic [19:0] npc;
    logic [2:0]  clr_loc;

    int checks = 0;
    int errors = 0;
    logic m_skip = 1'b0;

    always #2.5 clk = ~clk;

    bit_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .form(form), .skc(skc),
        .bit_val(bit_val), .flag_z(flag_z), .flag_cy(flag_cy), .disp(disp), .pc(pc),
        .plain_len(plain_len), .busy(busy), .done(done), .npc(npc), .taken(taken),
        .clr_req(clr_req), .clr_loc(clr_loc), .squash(squash), .skip_pend(skip_pend)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_len(input int o, input int f, input int pl);
        if (o == 1 || o == 2) return (f == 2 || f == 4) ? 3 : 4;
        if (o == 3) return 2;
        return pl;
    endfunction

    function automatic bit m_skc(input int c, input bit z, input bit cy);
        case (c)
            0: return cy;
            1: return !cy;
            2: return z;
            3: return !z;
            4: return !(z | cy);
            5: return (z | cy);
            default: return 0;
        endcase
    endfunction

    // Issue one instruction and check every result against the model.
    task automatic run(input int o, input int f, input int c, input bit b, input bit z,
                       input bit cy, input logic [7:0] d, input logic [19:0] p,
                       input int pl, input string req);
        int  len, n, seen;
        bit  tk, clr, sq, nskip, busy_ok;
        logic [19:0] exp_pc;
        len = m_len(o, f, pl);
        sq  = m_skip;
        tk  = 0;
        clr = 0;
        nskip = 0;
        n = 1;
        exp_pc = p + 20'(len);
        if (!sq) begin
            if (o == 1 || o == 2) begin
                tk  = (o == 1) ? !b : b;
                clr = tk && (o == 2);
                n   = (tk ? 5 : 3) + ((f == 5) ? 1 : 0);
                if (tk) exp_pc = p + 20'(len) + {{12{d[7]}}, d};
            end else if (o == 3) begin
                nskip = m_skc(c, z, cy);
            end
        end
        m_skip = nskip;
        @(negedge clk);
        issue = 1; op = 2'(o); form = 3'(f); skc = 3'(c); bit_val = b;
        flag_z = z; flag_cy = cy; disp = d; pc = p; plain_len = 3'(pl);
        @(negedge clk);
        issue = 0;
        seen = 0;
        busy_ok = 1;
        for (int i = 1; i <= 10; i++) begin
            if (done) begin seen = i; break; end
            if (!busy) busy_ok = 0;
            @(negedge clk);
        end
        chk(req, "R4 cycles", seen, n);
        chk(req, "R5 busy until done", busy_ok, 1);
        chk(req, "npc", npc, exp_pc);
        chk(req, "taken", taken, tk);
        chk(req, "R2 clr_req", clr_req, clr);
        if (clr) chk(req, "R2 clr_loc", clr_loc, f);
        chk(req, "R7 squash", squash, sq);
        chk(req, "R6/R8 skip_pend", skip_pend, nskip);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10", "busy", busy, 0);
        chk("R10", "done", done, 0);
        chk("R10", "skip_pend", skip_pend, 0);
    endtask

    task automatic t_brz();
        run(1, 0, 0, 0, 0, 0, 8'h10, 20'h00100, 1, "R1 taken fwd");
        run(1, 2, 0, 1, 0, 0, 8'h10, 20'h00100, 1, "R1 not taken acc");
        run(1, 4, 0, 0, 0, 0, 8'hF0, 20'h00200, 1, "R1 taken back ind");
        run(1, 5, 0, 0, 0, 0, 8'h05, 20'h00300, 1, "R4 seg taken");
        run(1, 5, 0, 1, 0, 0, 8'h05, 20'h00300, 1, "R4 seg not taken");
        run(1, 0, 0, 0, 0, 0, 8'h7F, 20'hFFFF0, 1, "R1 wrap high");
        run(1, 3, 0, 0, 0, 0, 8'h80, 20'h00010, 1, "R1 wrap low");
    endtask

    task automatic t_brsc();
        run(2, 3, 0, 1, 0, 0, 8'h20, 20'h01000, 1, "R2 psw taken");
        run(2, 1, 0, 0, 0, 0, 8'h20, 20'h01000, 1, "R2 not taken");
        run(2, 5, 0, 1, 0, 0, 8'hFE, 20'h02000, 1, "R2 seg taken");
        run(2, 6, 0, 1, 0, 0, 8'h01, 20'h03000, 1, "R3 rsv form len");
    endtask

    task automatic t_skip();
        for (int c = 0; c < 8; c++)
            for (int fz = 0; fz < 2; fz++)
                for (int fc = 0; fc < 2; fc++) begin
                    run(3, 0, c, 0, fz[0], fc[0], 8'h00, 20'h04000, 1, "R6 skip cond");
                    run(0, 0, 0, 0, 0, 0, 8'h00, 20'h04002, 3, "R7 follow");
                end
    endtask

    task automatic t_squash_forms();
        run(3, 0, 0, 0, 0, 1, 8'h00, 20'h05000, 1, "R6 arm");
        run(1, 0, 0, 0, 0, 0, 8'h40, 20'h05002, 1, "R7 squash brz");
        run(3, 0, 2, 0, 1, 0, 8'h00, 20'h05006, 1, "R6 arm");
        run(2, 2, 0, 1, 0, 0, 8'h40, 20'h05008, 1, "R7 squash brsc");
        run(3, 0, 3, 0, 0, 0, 8'h00, 20'h0500B, 1, "R6 arm");
        run(3, 0, 0, 0, 0, 1, 8'h00, 20'h0500D, 1, "R8 no chain");
        run(0, 0, 0, 0, 0, 0, 8'h00, 20'h0500F, 2, "R8 after");
    endtask

    task automatic t_plain();
        run(0, 0, 0, 0, 0, 0, 8'h00, 20'h06000, 1, "R9 len1");
        run(0, 0, 0, 0, 0, 0, 8'h00, 20'hFFFFE, 4, "R9 wrap");
    endtask

    task automatic t_ignore_busy();
        logic [19:0] exp_pc;
        int cnt;
        exp_pc = 20'h07000 + 20'd4 + 20'h00030;
        @(negedge clk);
        issue = 1; op = 2'd1; form = 3'd0; bit_val = 0; disp = 8'h30; pc = 20'h07000;
        @(negedge clk);
        issue = 1; op = 2'd0; pc = 20'h0A000; plain_len = 3'd1;
        cnt = 0;
        for (int i = 1; i <= 5; i++) begin
            if (done) cnt++;
            if (i == 3) issue = 0;
            if (i < 5) @(negedge clk);
        end
        chk("R5", "ignored issue: done count", cnt, 1);
        chk("R5", "ignored issue: npc", npc, exp_pc);
        chk("R5", "ignored issue: taken", taken, 1);
        @(negedge clk);
        chk("R5", "no stray done", done, 0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            run(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 20'($urandom),
                int'($urandom_range(1, 4)), "R1/R2/R3/R6 random");
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_brz();
        t_brsc();
        t_skip();
        t_squash_forms();
        t_plain();
        t_ignore_busy();
        t_random();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule